// File: doc/BRIEF.md
# Three-Channel Up-Counting Watchdog Timer

This block holds three watchdog channels that share one reference tick. Each channel has a free-running 32-bit up-counter, which software can read and overwrite at any time, a reset-compare register and a control register. When a channel is armed and its count has reached or passed its compare value, it requests a reset. Channel 0 requests a recovery-mode reset on its own output. Channels 1 and 2 share the normal system-reset output. Software keeps a channel alive by writing a low value into its counter before the counter catches up with the compare value.

Channel 0 also has a second compare register, which acts as an early-warning stage. When that stage is enabled and the count reaches the warning compare value, a sticky status bit sets and the interrupt output rises. Software clears the status by writing 1 to it. All registers sit behind a simple 32-bit single-cycle read/write port. Writes take effect on the clock edge, and reads are combinational.

Top module: `wdog_array_top`

## Requirements
- R1: After a synchronous active-low reset, every mapped register reads zero, and `irq_o`, `rst_recovery_o` and `rst_system_o` are low.
- R2: Each counter adds one on every clock edge where `tick_i` is high. A bus write to a counter loads the written value on that edge, and it takes priority over a tick in the same cycle.
- R3: A counter at 0xFFFFFFFF wraps to zero on the next tick.
- R4: A channel's reset request is high exactly while its reset-enable bit (control bit 2) is set and its count is greater than or equal to its reset-compare value. Writing a lower count removes the request. Channel 0 drives `rst_recovery_o`, and channels 1 and 2 together drive `rst_system_o` (logical OR).
- R5: When reset enable is set and both the reset-compare value and the count are zero, the request is present as soon as the last of those writes has landed, with no tick needed.
- R6: On channel 0, when interrupt enable (control bit 0) is set and the count is greater than or equal to the warning compare value, the status bit (control bit 1) sets on the following edge. It then stays set whatever the count does. `irq_o` equals status AND enable.
- R7: Writing a control word with bit 1 = 1 clears channel 0's status. Bit 1 = 0 leaves it unchanged. If the warning condition still holds in that same cycle, the status stays set.
- R8: Channels 1 and 2 have no warning stage: control bits 0 and 1 read as zero, writes to them have no effect, and they never raise `irq_o`.
- R9: Word offsets (hex): channel 0 at 00 counter, 04 reset compare, 08 warning compare, 0C control. Channel 1 at 10, 14, 1C and channel 2 at 20, 24, 2C (counter, reset compare, control).
- R10: Offsets not listed in R9 (including 18, 28, 30–3C and any offset whose low two bits are not zero) read as zero, and writes to them change no register.
- R11: A control register reads back with interrupt enable in bit 0, status in bit 1, reset enable in bit 2, and zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Reference tick; each counter increments on edges where it is high |
| bus_wr_i | input | 1 | Write strobe for the register port |
| bus_addr_i | input | 6 | Byte offset of the register accessed |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| irq_o | output | 1 | Channel 0 early-warning interrupt |
| rst_recovery_o | output | 1 | Recovery-mode reset request from channel 0 |
| rst_system_o | output | 1 | Normal reset request from channel 1 or 2 |

## Verification
The hardest state to reach is a clear request on channel 0 in the same cycle that the warning condition still holds, because the counter must sit at or above the warning value at that exact edge. The bench holds `tick_i` low so that every counter stays frozen. It parks the count above the warning value and then issues the write-1 clear. It also checks the case where the count was already rewritten below the value, so that it can tell "set wins" from a plain clear. The one-cycle gap between a count crossing the warning value and the status bit setting is checked on both sides of the edge.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
// Shared constants for the watchdog array: control bit positions and the
// register slot numbering inside one channel's 16-byte window.
package wdog_pkg;
    localparam int DATA_W   = 32;
    localparam int CTRL_IE  = 0;   // interrupt enable
    localparam int CTRL_ST  = 1;   // interrupt status, write 1 to clear
    localparam int CTRL_RE  = 2;   // reset enable

    typedef enum logic [1:0] {
        SLOT_CNT  = 2'd0,
        SLOT_RCMP = 2'd1,
        SLOT_WCMP = 2'd2,
        SLOT_CTRL = 2'd3
    } slot_e;
endpackage

// File: rtl/wdog_addr_dec.sv
`timescale 1ns/1ps
// Address decoder for the watchdog array.
// Splits a byte offset into channel index and register slot, flags offsets
// that map to no register and produces one write strobe per channel register.
// Assumes each channel owns a 16-byte window and that only channels whose bit
// is set in WARN_MASK have the warning-compare slot.
module wdog_addr_dec
    import wdog_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_CH    = 3,
    parameter logic [NUM_CH-1:0] WARN_MASK = 3'b001
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output logic              hit_o,
    output slot_e             slot_o,
    output logic [NUM_CH-1:0] ch_sel_o,
    output logic [NUM_CH-1:0] wr_cnt_o,
    output logic [NUM_CH-1:0] wr_rcmp_o,
    output logic [NUM_CH-1:0] wr_wcmp_o,
    output logic [NUM_CH-1:0] wr_ctrl_o
);
    localparam int CH_W = ADDR_W - 4;

    logic [CH_W-1:0] ch_idx;
    logic            aligned;

    assign ch_idx  = addr_i[ADDR_W-1:4];
    assign slot_o  = slot_e'(addr_i[3:2]);
    assign aligned = (addr_i[1:0] == 2'b00);

    // Decode the channel select; the warning slot exists only where enabled.
    always_comb begin
        ch_sel_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (aligned && (int'(ch_idx) == i)) begin
                ch_sel_o[i] = (slot_o != SLOT_WCMP) || WARN_MASK[i];
            end
        end
    end

    assign hit_o = |ch_sel_o;

    // Per-channel write strobes, one per register slot.
    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_strobe
            assign wr_cnt_o[g]  = wr_i && ch_sel_o[g] && (slot_o == SLOT_CNT);
            assign wr_rcmp_o[g] = wr_i && ch_sel_o[g] && (slot_o == SLOT_RCMP);
            assign wr_wcmp_o[g] = wr_i && ch_sel_o[g] && (slot_o == SLOT_WCMP);
            assign wr_ctrl_o[g] = wr_i && ch_sel_o[g] && (slot_o == SLOT_CTRL);
        end
    endgenerate
endmodule

// File: rtl/wdog_chan.sv
`timescale 1ns/1ps
// One watchdog channel: up-counter, reset compare, control and, when
// HAS_WARN is set, a warning compare with a sticky write-1-to-clear status.
// Assumes the decoder gives at most one write strobe per cycle. The reset
// request is a level decoded from registered state.
module wdog_chan
    import wdog_pkg::*;
#(
    parameter int DW       = DATA_W,
    parameter bit HAS_WARN = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          wr_cnt_i,
    input  logic          wr_rcmp_i,
    input  logic          wr_wcmp_i,
    input  logic          wr_ctrl_i,
    input  slot_e         slot_i,
    output logic [DW-1:0] rdata_o,
    output logic          rst_req_o,
    output logic          irq_o
);
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] rcmp_q;
    logic          rst_en_q;
    logic          ie_w;
    logic          st_w;
    logic [DW-1:0] wcmp_w;

    // Counter: a bus load wins over a tick, and the count wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (wr_cnt_i)   cnt_q <= wdata_i;
        else if (tick_i)     cnt_q <= cnt_q + 1'b1;
    end

    // Reset-compare register and the reset-enable control bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcmp_q   <= '0;
            rst_en_q <= 1'b0;
        end else begin
            if (wr_rcmp_i) rcmp_q   <= wdata_i;
            if (wr_ctrl_i) rst_en_q <= wdata_i[CTRL_RE];
        end
    end

    assign rst_req_o = rst_en_q && (cnt_q >= rcmp_q);

    generate
        if (HAS_WARN) begin : g_warn
            logic [DW-1:0] wcmp_q;
            logic          ie_q;
            logic          st_q;
            logic          warn_hit;
            logic          st_clr;

            assign warn_hit = ie_q && (cnt_q >= wcmp_q);
            assign st_clr   = wr_ctrl_i && wdata_i[CTRL_ST];

            // Warning compare and interrupt-enable registers.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    wcmp_q <= '0;
                    ie_q   <= 1'b0;
                end else begin
                    if (wr_wcmp_i) wcmp_q <= wdata_i;
                    if (wr_ctrl_i) ie_q   <= wdata_i[CTRL_IE];
                end
            end

            // Sticky status: a new hit outranks a clear in the same cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= 1'b0;
                else        st_q <= (st_q && !st_clr) || warn_hit;
            end

            assign ie_w   = ie_q;
            assign st_w   = st_q;
            assign wcmp_w = wcmp_q;

            // R6: once set, status holds until a write-1 clear.
            p_stat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q && !st_clr) |=> st_q);
            // R7: a clear with no hit in the same cycle empties the status.
            p_stat_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (st_clr && !(ie_q && (cnt_q >= wcmp_q))) |=> !st_q);
        end else begin : g_nowarn
            logic unused_wcmp_wr;
            assign unused_wcmp_wr = wr_wcmp_i;
            assign ie_w   = 1'b0;
            assign st_w   = 1'b0;
            assign wcmp_w = '0;
        end
    endgenerate

    assign irq_o = st_w && ie_w;

    // Read mux over this channel's slots.
    always_comb begin
        rdata_o = '0;
        case (slot_i)
            SLOT_CNT:  rdata_o = cnt_q;
            SLOT_RCMP: rdata_o = rcmp_q;
            SLOT_WCMP: rdata_o = wcmp_w;
            SLOT_CTRL: begin
                rdata_o[CTRL_IE] = ie_w;
                rdata_o[CTRL_ST] = st_w;
                rdata_o[CTRL_RE] = rst_en_q;
            end
            default:   rdata_o = '0;
        endcase
    end

    // R2: a bus load lands on the next edge.
    p_cnt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> (cnt_q == $past(wdata_i)));
    // R2/R3: a tick without a load advances by one, wrapping at the top.
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_cnt_i) |=> (cnt_q == DW'($past(cnt_q) + 1'b1)));
    // R4: loading a count below the compare removes the request.
    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt_i && !wr_rcmp_i && (wdata_i < rcmp_q)) |=> !rst_req_o);
endmodule

// File: rtl/wdog_array_top.sv
`timescale 1ns/1ps
// Top of the three-channel watchdog array.
// Instantiates the address decoder and one channel per index, gives the
// warning stage to channel 0 only, merges the read data and routes the reset
// requests: channel 0 to recovery, the rest ORed into system reset.
// Assumes a single-cycle register port with combinational read data.
module wdog_array_top
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              rst_recovery_o,
    output logic              rst_system_o
);
    localparam logic [NUM_CH-1:0] WARN_MASK = NUM_CH'(1);

    logic              hit;
    slot_e             slot;
    logic [NUM_CH-1:0] ch_sel;
    logic [NUM_CH-1:0] wr_cnt, wr_rcmp, wr_wcmp, wr_ctrl;
    logic [NUM_CH-1:0] req, irq;
    logic [DATA_W-1:0] rd_vec [NUM_CH];

    wdog_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_CH   (NUM_CH),
        .WARN_MASK(WARN_MASK)
    ) u_dec (
        .addr_i   (bus_addr_i),
        .wr_i     (bus_wr_i),
        .hit_o    (hit),
        .slot_o   (slot),
        .ch_sel_o (ch_sel),
        .wr_cnt_o (wr_cnt),
        .wr_rcmp_o(wr_rcmp),
        .wr_wcmp_o(wr_wcmp),
        .wr_ctrl_o(wr_ctrl)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            wdog_chan #(
                .DW      (DATA_W),
                .HAS_WARN(WARN_MASK[g])
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick_i   (tick_i),
                .wdata_i  (bus_wdata_i),
                .wr_cnt_i (wr_cnt[g]),
                .wr_rcmp_i(wr_rcmp[g]),
                .wr_wcmp_i(wr_wcmp[g]),
                .wr_ctrl_i(wr_ctrl[g]),
                .slot_i   (slot),
                .rdata_o  (rd_vec[g]),
                .rst_req_o(req[g]),
                .irq_o    (irq[g])
            );
        end
    endgenerate

    // Merge read data from the selected channel; unmapped offsets give zero.
    always_comb begin
        bus_rdata_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_sel[i]) bus_rdata_o = bus_rdata_o | rd_vec[i];
        end
    end

    assign irq_o          = |irq;
    assign rst_recovery_o = req[0];
    assign rst_system_o   = |req[NUM_CH-1:1];

    // R10: an offset that hits no register returns zero.
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata_o == '0));
    // R10: a write to an unmapped offset strobes no register.
    p_unmapped_nowr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> ((wr_cnt | wr_rcmp | wr_wcmp | wr_ctrl) == '0));
endmodule

// File: tb/sim_wdog_array_top.sv
`timescale 1ns/1ps
// Directed bench for the watchdog array: one task per scenario.
module sim_wdog_array_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rrec, rsys;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    wdog_array_top u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .rst_recovery_o(rrec), .rst_system_o(rsys)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic rchk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rreg(a, d);
        chk(req, d, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [5:0] regs [10] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10,
                                  6'h14, 6'h1C, 6'h20, 6'h24, 6'h2C};
        for (int i = 0; i < 10; i++) rchk("R1", regs[i], 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 recovery", {31'b0, rrec}, 32'h0);
        chk("R1 system", {31'b0, rsys}, 32'h0);
    endtask

    task automatic t_count;
        wreg(6'h10, 32'h100);
        ticks(7);
        rchk("R2 step", 6'h10, 32'h107);
        rchk("R2 shared tick", 6'h20, 32'h7);
        // load and tick in the same cycle: load wins
        @(negedge clk);
        tick = 1'b1; wr = 1'b1; addr = 6'h10; wdata = 32'd50;
        @(negedge clk);
        tick = 1'b0; wr = 1'b0;
        rchk("R2 priority", 6'h10, 32'd50);
        wreg(6'h10, 32'hFFFF_FFFE);
        ticks(3);
        rchk("R3 wrap", 6'h10, 32'h1);
    endtask

    task automatic t_sysreset;
        wreg(6'h14, 32'd100);
        wreg(6'h10, 32'd98);
        wreg(6'h1C, 32'h4);
        chk("R4 below", {31'b0, rsys}, 32'h0);
        ticks(1);
        chk("R4 one below", {31'b0, rsys}, 32'h0);
        ticks(1);
        chk("R4 equal", {31'b0, rsys}, 32'h1);
        chk("R4 recovery quiet", {31'b0, rrec}, 32'h0);
        ticks(2);
        chk("R4 above", {31'b0, rsys}, 32'h1);
        wreg(6'h10, 32'd3);
        chk("R4 deassert", {31'b0, rsys}, 32'h0);
        wreg(6'h14, 32'd2);
        chk("R4 compare lowered", {31'b0, rsys}, 32'h1);
        wreg(6'h1C, 32'h0);
        chk("R4 disarm", {31'b0, rsys}, 32'h0);
        wreg(6'h24, 32'h20);
        wreg(6'h20, 32'h20);
        wreg(6'h2C, 32'h4);
        chk("R4 ch2", {31'b0, rsys}, 32'h1);
        wreg(6'h2C, 32'h0);
        chk("R4 ch2 off", {31'b0, rsys}, 32'h0);
    endtask

    task automatic t_immediate;
        wreg(6'h0C, 32'h4);
        wreg(6'h04, 32'h0);
        wreg(6'h00, 32'h0);
        chk("R5 immediate", {31'b0, rrec}, 32'h1);
        chk("R5 system quiet", {31'b0, rsys}, 32'h0);
        wreg(6'h0C, 32'h0);
        chk("R5 release", {31'b0, rrec}, 32'h0);
    endtask

    task automatic t_warn;
        wreg(6'h04, 32'hFFFF_FFFF);
        wreg(6'h08, 32'd10);
        wreg(6'h00, 32'd5);
        wreg(6'h0C, 32'h5);
        idle(1);
        chk("R6 below", {31'b0, irq}, 32'h0);
        rchk("R11 layout", 6'h0C, 32'h5);
        ticks(5);
        chk("R6 one edge late", {31'b0, irq}, 32'h0);
        idle(1);
        chk("R6 set", {31'b0, irq}, 32'h1);
        rchk("R11 status bit", 6'h0C, 32'h7);
        chk("R6 recovery quiet", {31'b0, rrec}, 32'h0);
        wreg(6'h00, 32'd0);
        idle(1);
        chk("R6 sticky", {31'b0, irq}, 32'h1);
        wreg(6'h0C, 32'h5);
        chk("R7 write0 keeps", {31'b0, irq}, 32'h1);
        wreg(6'h0C, 32'h7);
        chk("R7 clear", {31'b0, irq}, 32'h0);
        rchk("R7 readback", 6'h0C, 32'h5);
        wreg(6'h00, 32'd20);
        idle(1);
        chk("R6 reset by count", {31'b0, irq}, 32'h1);
        wreg(6'h0C, 32'h7);
        chk("R7 hit outranks clear", {31'b0, irq}, 32'h1);
        wreg(6'h0C, 32'h0);
        chk("R6 gated", {31'b0, irq}, 32'h0);
        rchk("R6 status kept", 6'h0C, 32'h2);
        wreg(6'h0C, 32'h2);
        rchk("R7 clear disabled", 6'h0C, 32'h0);
    endtask

    task automatic t_nowarn;
        wreg(6'h14, 32'hFFFF_FFFF);
        wreg(6'h10, 32'd0);
        wreg(6'h1C, 32'h7);
        idle(2);
        rchk("R8 ctrl bits", 6'h1C, 32'h4);
        chk("R8 no irq", {31'b0, irq}, 32'h0);
        wreg(6'h1C, 32'h0);
    endtask

    task automatic t_map;
        wreg(6'h18, 32'hDEAD_BEEF);
        rchk("R10 hole read", 6'h18, 32'h0);
        rchk("R10 neighbour", 6'h14, 32'hFFFF_FFFF);
        wreg(6'h05, 32'h1234);
        rchk("R10 misaligned", 6'h05, 32'h0);
        rchk("R10 misaligned wr", 6'h04, 32'hFFFF_FFFF);
        wreg(6'h30, 32'h55);
        rchk("R10 ch3", 6'h30, 32'h0);
        wreg(6'h24, 32'h2222);
        wreg(6'h28, 32'h3333);
        rchk("R9 ch2 compare", 6'h24, 32'h2222);
        rchk("R9 ch2 hole", 6'h28, 32'h0);
        wreg(6'h08, 32'h0808);
        rchk("R9 ch0 warn", 6'h08, 32'h0808);
        chk("R10 no side effect", {29'b0, irq, rrec, rsys}, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_sysreset();
        t_immediate();
        t_warn();
        t_nowarn();
        t_map();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule